// File: doc/BRIEF.md
# Operand Precision Classifier and Steering Unit

This block takes the two operands of a multiplication one after the other over a single 32-bit word port. A select input tells which operand is on the port: select low carries the first operand, select high carries the second. Each word is taken only when the valid strobe is high. When the second operand of a pair is taken, the block finds the narrowest precision class that holds the larger of the two values. It then loads both operands into the output register pair that belongs to that class.

There are three classes. Values below 256 form the narrow class, values below 32768 form the middle class, and all other values form the wide class. The block puts out a 2-bit class code together with a one-cycle result strobe. A downstream clock-rate selector uses the code: code 1 runs the multiplier at a quarter of the clock rate, code 2 at half rate and code 3 at full rate. Register pairs that are not selected keep their contents, so each pair only changes when a multiply of its own class arrives.

Top module: `prec_steer`

## Requirements
- R1: During synchronous reset `rst`, and in the cycle that follows it, `prec_code` is 0 (no result yet), `res_valid` is 0 and all six operand outputs are 0.
- R2: A word is taken as the first operand when `in_valid`=1 and `in_sel`=0. A later such word replaces the pending first operand, so the most recent one is used.
- R3: A word with `in_valid`=1 and `in_sel`=1 is taken as the second operand only when a first operand is pending. If no first operand is pending, the word is ignored: there is no result strobe, and the code and the outputs do not change.
- R4: `res_valid` is high for exactly one cycle, in the cycle right after the clock edge that takes the second operand. `prec_code` and the selected pair change on that same edge.
- R5: If the larger operand is below 256, `prec_code` becomes 1. The low 8 bits of the first and second operand load `nar_a` and `nar_b`.
- R6: If the larger operand is at least 256 and below 32768, `prec_code` becomes 2. The low 16 bits load `mid_a` and `mid_b`.
- R7: If the larger operand is 32768 or more, `prec_code` becomes 3. The full words load `wid_a` and `wid_b`.
- R8: The two register pairs that are not selected by a result keep their previous values.
- R9: `prec_code` keeps its value between results. Once a pair completes, no first operand is pending, so a following select-high word is ignored until a new first operand arrives.
- R10: Cycles with `in_valid`=0 have no effect, whatever the values on `in_sel` and `in_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word strobe |
| in_sel | input | 1 | 0 = first operand, 1 = second operand |
| in_word | input | 32 | Operand word |
| prec_code | output | 2 | Class code: 0 none, 1 narrow, 2 middle, 3 wide |
| res_valid | output | 1 | One-cycle result strobe |
| nar_a | output | 8 | Narrow-class first operand |
| nar_b | output | 8 | Narrow-class second operand |
| mid_a | output | 16 | Middle-class first operand |
| mid_b | output | 16 | Middle-class second operand |
| wid_a | output | 32 | Wide-class first operand |
| wid_b | output | 32 | Wide-class second operand |

## Verification
The bench tests both sides of each threshold: 255 against 256, and 32767 against 32768. A design that used an inclusive compare, or that classified on only one operand, would put those pairs in the wrong class. Directed sequences cover a select-high word with no first operand pending, a repeated first operand, and idle cycles that carry junk on the bus. A design that did not track whether a first operand is pending would give a false strobe or pair with a stale word. After every result, all three register pairs are compared against a model, so a design that cleared or overwrote an unselected pair is caught.

// File: rtl/prec_pkg.sv
package prec_pkg;
  typedef enum logic [1:0] {
    PC_NONE   = 2'd0,
    PC_NARROW = 2'd1,
    PC_MID    = 2'd2,
    PC_WIDE   = 2'd3
  } prec_e;
endpackage

// File: rtl/opd_capture.sv
module opd_capture #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sel,
  input  logic [WORD_W-1:0] in_word,
  output logic [WORD_W-1:0] first_q,
  output logic              pend_q,
  output logic              cap_first,
  output logic              cap_second
);
  assign cap_first  = in_valid && !in_sel;
  assign cap_second = in_valid && in_sel && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      pend_q  <= 1'b0;
    end else if (cap_first) begin
      first_q <= in_word;
      pend_q  <= 1'b1;
    end else if (cap_second) begin
      pend_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/prec_classify.sv
module prec_classify
  import prec_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int LO_BITS  = 8,
  parameter int MID_BITS = 15
) (
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output prec_e             cls
);
  function automatic prec_e class_of(input logic [WORD_W-1:0] a,
                                     input logic [WORD_W-1:0] b);
    logic [WORD_W-1:0] big;
    big = (a > b) ? a : b;
    if ((big >> LO_BITS) == '0)       return PC_NARROW;
    else if ((big >> MID_BITS) == '0) return PC_MID;
    else                              return PC_WIDE;
  endfunction

  assign cls = class_of(opa, opb);
endmodule

// File: rtl/pair_reg.sv
module pair_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] da,
  input  logic [PW-1:0] db,
  output logic [PW-1:0] qa,
  output logic [PW-1:0] qb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      qa <= '0;
      qb <= '0;
    end else if (load) begin
      qa <= da;
      qb <= db;
    end
  end
endmodule

// File: rtl/prec_steer.sv
module prec_steer
  import prec_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NAR_W  = 8,
  parameter int MID_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sel,
  input  logic [WORD_W-1:0] in_word,
  output logic [1:0]        prec_code,
  output logic              res_valid,
  output logic [NAR_W-1:0]  nar_a,
  output logic [NAR_W-1:0]  nar_b,
  output logic [MID_W-1:0]  mid_a,
  output logic [MID_W-1:0]  mid_b,
  output logic [WORD_W-1:0] wid_a,
  output logic [WORD_W-1:0] wid_b
);
  localparam int LO_BITS  = NAR_W;
  localparam int MID_BITS = MID_W - 1;

  logic [WORD_W-1:0] first_q;
  logic              pend_q;
  logic              cap_first;
  logic              cap_second;
  prec_e             cls;
  logic              ld_nar, ld_mid, ld_wid;

  opd_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
    .in_word(in_word), .first_q(first_q), .pend_q(pend_q),
    .cap_first(cap_first), .cap_second(cap_second)
  );

  prec_classify #(.WORD_W(WORD_W), .LO_BITS(LO_BITS), .MID_BITS(MID_BITS)) u_cls (
    .opa(first_q), .opb(in_word), .cls(cls)
  );

  assign ld_nar = cap_second && (cls == PC_NARROW);
  assign ld_mid = cap_second && (cls == PC_MID);
  assign ld_wid = cap_second && (cls == PC_WIDE);

  pair_reg #(.PW(NAR_W)) u_nar (
    .clk(clk), .rst(rst), .load(ld_nar),
    .da(first_q[NAR_W-1:0]), .db(in_word[NAR_W-1:0]), .qa(nar_a), .qb(nar_b)
  );

  pair_reg #(.PW(MID_W)) u_mid (
    .clk(clk), .rst(rst), .load(ld_mid),
    .da(first_q[MID_W-1:0]), .db(in_word[MID_W-1:0]), .qa(mid_a), .qb(mid_b)
  );

  pair_reg #(.PW(WORD_W)) u_wid (
    .clk(clk), .rst(rst), .load(ld_wid),
    .da(first_q), .db(in_word), .qa(wid_a), .qb(wid_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prec_code <= PC_NONE;
      res_valid <= 1'b0;
    end else begin
      res_valid <= cap_second;
      if (cap_second) prec_code <= cls;
    end
  end
endmodule

// File: rtl/prec_steer_chk.sv
module prec_steer_chk #(
  parameter int WORD_W = 32,
  parameter int NAR_W  = 8,
  parameter int MID_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_sel,
  input logic              pend_q,
  input logic              cap_second,
  input logic [1:0]        prec_code,
  input logic              res_valid,
  input logic [NAR_W-1:0]  nar_a,
  input logic [MID_W-1:0]  mid_a,
  input logic [WORD_W-1:0] wid_a
);
  // R4: strobe follows the second capture and lasts one cycle
  p_pulse_after_r4: assert property (@(posedge clk) disable iff (rst)
    cap_second |=> res_valid);
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R3: select high with nothing pending produces no result
  p_orphan_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sel && !pend_q) |=> !res_valid);
  // R9: code only moves with a result
  p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(prec_code));
  // R5..R7: a result always carries a real class
  p_code_real_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> prec_code != 2'd0);
  // R8: unselected pairs keep their contents
  p_keep_nar_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && prec_code != 2'd1) |-> $stable(nar_a));
  p_keep_mid_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && prec_code != 2'd2) |-> $stable(mid_a));
  p_keep_wid_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && prec_code != 2'd3) |-> $stable(wid_a));
endmodule

bind prec_steer prec_steer_chk #(.WORD_W(WORD_W), .NAR_W(NAR_W), .MID_W(MID_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
  .pend_q(pend_q), .cap_second(cap_second), .prec_code(prec_code),
  .res_valid(res_valid), .nar_a(nar_a), .mid_a(mid_a), .wid_a(wid_a)
);

// File: tb/tb_prec_steer.sv
`timescale 1ns/1ps
module tb_prec_steer;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_sel;
  logic [31:0] in_word;
  logic [1:0]  prec_code;
  logic        res_valid;
  logic [7:0]  nar_a, nar_b;
  logic [15:0] mid_a, mid_b;
  logic [31:0] wid_a, wid_b;

  int checks = 0;
  int errors = 0;
  logic        done = 1'b0;

  logic [1:0]  m_code;
  logic [7:0]  m_na, m_nb;
  logic [15:0] m_ma, m_mb;
  logic [31:0] m_wa, m_wb;

  always #2.5 clk = ~clk;

  prec_steer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel), .in_word(in_word),
    .prec_code(prec_code), .res_valid(res_valid),
    .nar_a(nar_a), .nar_b(nar_b), .mid_a(mid_a), .mid_b(mid_b),
    .wid_a(wid_a), .wid_b(wid_b)
  );

  function automatic logic [1:0] ref_code(input logic [31:0] a, input logic [31:0] b);
    if (a < 32'd256 && b < 32'd256)     return 2'd1;
    if (a < 32'd32768 && b < 32'd32768) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " code"}, 64'(prec_code), 64'(m_code));
    chk({req, " nar"}, {48'd0, nar_a, nar_b}, {48'd0, m_na, m_nb});
    chk({req, " mid"}, {32'd0, mid_a, mid_b}, {32'd0, m_ma, m_mb});
    chk({req, " wid"}, {wid_a, wid_b}, {m_wa, m_wb});
  endtask

  task automatic put(input logic [31:0] w, input logic s);
    @(negedge clk);
    in_valid = 1'b1; in_sel = s; in_word = w;
    @(negedge clk);
    in_valid = 1'b0; in_word = $urandom; in_sel = 1'($urandom);
  endtask

  task automatic expect_result(input logic [31:0] a, input logic [31:0] b, input string req);
    m_code = ref_code(a, b);
    case (m_code)
      2'd1: begin m_na = a[7:0];  m_nb = b[7:0];  end
      2'd2: begin m_ma = a[15:0]; m_mb = b[15:0]; end
      default: begin m_wa = a; m_wb = b; end
    endcase
    chk({req, " R4 strobe"}, 64'(res_valid), 64'd1);
    chk_all(req);
    @(negedge clk);
    chk({req, " R4 single"}, 64'(res_valid), 64'd0);
  endtask

  task automatic pair(input logic [31:0] a, input logic [31:0] b, input string req);
    put(a, 1'b0);
    put(b, 1'b1);
    expect_result(a, b, req);
  endtask

  function automatic logic [31:0] rand_in(input int cls);
    case (cls)
      0: return $urandom & 32'h0000_00FF;
      1: return $urandom & 32'h0000_7FFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    m_code = 0; m_na = 0; m_nb = 0; m_ma = 0; m_mb = 0; m_wa = 0; m_wb = 0;
    rst = 1'b1; in_valid = 1'b0; in_sel = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    chk("R1 strobe", 64'(res_valid), 64'd0);
    chk_all("R1");
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 post");

    // R5/R6/R7 threshold edges
    pair(32'd56, 32'd135, "R5 small");
    pair(32'd255, 32'd255, "R5 edge");
    pair(32'd255, 32'd256, "R6 edge lo");
    pair(32'd2456, 32'd756, "R6 mid");
    pair(32'd32767, 32'd0, "R6 edge hi");
    pair(32'd0, 32'd32768, "R7 edge");
    pair(32'd3562145, 32'd249632166, "R7 wide");
    pair(32'hFFFF_FFFF, 32'd3, "R7 one wide R8");

    // R3: select high with nothing pending
    put(32'h1234_5678, 1'b1);
    chk("R3 no strobe", 64'(res_valid), 64'd0);
    chk_all("R3 unchanged");

    // R2: latest first operand wins
    put(32'h0001_0000, 1'b0);
    put(32'd17, 1'b0);
    put(32'd200, 1'b1);
    expect_result(32'd17, 32'd200, "R2 replace");

    // R9: after completion, a second word alone is ignored
    put(32'd99, 1'b1);
    chk("R9 no strobe", 64'(res_valid), 64'd0);
    chk_all("R9 hold");

    // R10: idle cycles carry junk
    put(32'd300, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sel = 1'(i); in_word = 32'hDEAD_0000 | 32'(i);
    end
    chk("R10 no strobe", 64'(res_valid), 64'd0);
    chk_all("R10 idle");
    put(32'd5, 1'b1);
    expect_result(32'd300, 32'd5, "R10 kept first");

    // random pairs, R5/R6/R7/R8
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a, b;
      a = rand_in(int'($urandom % 3));
      b = rand_in(int'($urandom % 3));
      pair(a, b, "R8 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule